// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block holds the 32-bit status and control word of a floating-point unit. Software can overwrite the whole word at any time. An arithmetic datapath reports its results through two narrower paths. One is an exception-request word, whose flags are ORed into the register and never cleared by hardware. The other is a 5-bit result-class code, which replaces one field and leaves the rest of the word untouched.

On each exception update the unit keeps two summary flags current. The first marks that some exception flag has just changed from 0 to 1. The second marks that at least one invalid-operation detail flag is set. The unit also provides the rounding-mode field as a one-hot select and copies the four most significant status bits into a 4-bit condition field. All bit positions below use LSB-0 numbering on the 32-bit word. All changes take effect on the next rising clock edge.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word reads 0, the rounding select shows nearest-even (4'b0001) and the condition field is 0.
- R2: A software write stores its 32-bit value unchanged, with no summary recomputation. It wins over an exception update or a class write in the same cycle.
- R3: An exception update ORs the requested flags into the register. No update other than a software write ever clears an exception flag. The flags are overflow (28), underflow (27), divide-by-zero (26), inexact (25) and the invalid details at 24, 23, 22, 21, 20, 19, 10, 9 and 8.
- R4: Requested bits outside those thirteen positions have no effect on the register.
- R5: Bit 31 (new-exception summary) is set when an exception update moves any of the thirteen flags from 0 to 1.
- R6: An exception update whose requested flags are all already set leaves bit 31 as it was.
- R7: After an exception update, bit 29 (invalid summary) is set whenever any invalid-detail flag (bits 24..19, 10..8) is set.
- R8: A class write replaces bits [16:12] with the 5-bit code and leaves all other bits unchanged.
- R9: The rounding select is one-hot from bits [1:0]. 00 drives bit 0 (nearest-even), 01 drives bit 1 (toward zero), 10 drives bit 2 (toward +infinity) and 11 drives bit 3 (toward -infinity).
- R10: The condition field equals status bits {31,30,29,28} as {lt, gt, eq, so}, MSB first.
- R11: An exception update and a class write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software full-word write strobe |
| sw_wr_data | input | 32 | Software write value |
| exc_upd_en | input | 1 | Exception update strobe |
| exc_upd_bits | input | 32 | Requested exception flags, word-aligned |
| cls_wr_en | input | 1 | Result-class write strobe |
| cls_wr_code | input | 5 | Result-class code for bits [16:12] |
| status_q | output | 32 | Current status and control word |
| round_sel | output | 4 | One-hot rounding mode |
| cond_field | output | 4 | Copy of bits 31..28 |

## Verification
On every cycle the assertions check several behaviours. A software write must land verbatim. Exception flags must stay sticky. A 0-to-1 flag change must raise bit 31, and bit 31 must stay low when nothing new appears. The invalid summary must follow the detail flags, a class write must land in its field, and an idle cycle must leave the word unchanged. Only the bench's scenarios show the full picture for each of the thirteen flags taken alone: first raised from clear, then re-asserted while already set. The same holds for the other bench scenarios: the class field swept over all 32 codes on a busy background, priority when all three write paths collide, and request bits that must be ignored.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int WORD_W  = 32;
  localparam int CLS_W   = 5;
  localparam int CLS_LSB = 12;
  localparam int RM_W    = 2;
  localparam int RM_N    = 1 << RM_W;
  localparam int COND_W  = 4;

  localparam int BIT_NEWX = 31;
  localparam int BIT_INVS = 29;

  // invalid-detail flags: 24..19 and 10..8
  localparam logic [WORD_W-1:0] INV_DETAIL_MASK = 32'h01F8_0700;
  // overflow, underflow, divide-by-zero, inexact: 28..25
  localparam logic [WORD_W-1:0] ARITH_FLAG_MASK = 32'h1E00_0000;
  localparam logic [WORD_W-1:0] STICKY_MASK     = INV_DETAIL_MASK | ARITH_FLAG_MASK;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_PINF   = 2'b10,
    RM_TO_NINF   = 2'b11
  } round_mode_e;
endpackage

// File: rtl/fpsu_exc_merge.sv
module fpsu_exc_merge
  import fpsu_pkg::*;
(
  input  logic [WORD_W-1:0] cur_word,
  input  logic              upd_en,
  input  logic [WORD_W-1:0] upd_bits,
  output logic [WORD_W-1:0] merged_word
);
  logic [WORD_W-1:0] req_flags;
  logic [WORD_W-1:0] rising;
  logic [WORD_W-1:0] ored;

  always_comb begin
    req_flags   = upd_bits & STICKY_MASK;
    rising      = req_flags & ~cur_word;
    ored        = cur_word | req_flags;
    merged_word = cur_word;
    if (upd_en) begin
      merged_word = ored;
      if (|rising) begin
        merged_word[BIT_NEWX] = 1'b1;
      end
      if (|(ored & INV_DETAIL_MASK)) begin
        merged_word[BIT_INVS] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpsu_rm_decode.sv
module fpsu_rm_decode
  import fpsu_pkg::*;
(
  input  logic [RM_W-1:0] rm_code,
  output logic [RM_N-1:0] rm_onehot
);
  for (genvar g = 0; g < RM_N; g++) begin : g_sel
    assign rm_onehot[g] = (rm_code == RM_W'(g));
  end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [WORD_W-1:0] sw_wr_data,
  input  logic              exc_upd_en,
  input  logic [WORD_W-1:0] exc_upd_bits,
  input  logic              cls_wr_en,
  input  logic [CLS_W-1:0]  cls_wr_code,
  output logic [WORD_W-1:0] status_q,
  output logic [RM_N-1:0]   round_sel,
  output logic [COND_W-1:0] cond_field
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] status_d;
  logic              status_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  fpsu_exc_merge u_merge (
    .cur_word    (status_q),
    .upd_en      (exc_upd_en),
    .upd_bits    (exc_upd_bits),
    .merged_word (merged)
  );

  always_comb begin
    status_load = sw_wr_en | exc_upd_en | cls_wr_en;
    status_d    = merged;
    if (sw_wr_en) begin
      status_d = sw_wr_data;
    end else if (cls_wr_en) begin
      status_d[CLS_LSB +: CLS_W] = cls_wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      status_q <= '0;
    end else if (status_load) begin
      status_q <= status_d;
    end
  end

  fpsu_rm_decode u_rm (
    .rm_code   (status_q[RM_W-1:0]),
    .rm_onehot (round_sel)
  );

  assign cond_field = status_q[WORD_W-1 -: COND_W];
endmodule

// File: rtl/fpsu_chk.sv
module fpsu_chk
  import fpsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              sw_wr_en,
  input logic [WORD_W-1:0] sw_wr_data,
  input logic              exc_upd_en,
  input logic [WORD_W-1:0] exc_upd_bits,
  input logic              cls_wr_en,
  input logic [CLS_W-1:0]  cls_wr_code,
  input logic [WORD_W-1:0] status_q,
  input logic [RM_N-1:0]   round_sel
);
  AST_SW_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n_s)
    sw_wr_en |=> status_q == $past(sw_wr_data)); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sw_wr_en |=> ((status_q & $past(status_q) & STICKY_MASK) == ($past(status_q) & STICKY_MASK))); // R3

  AST_NEWX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sw_wr_en && exc_upd_en && |(exc_upd_bits & STICKY_MASK & ~status_q)) |=> status_q[BIT_NEWX]); // R5

  AST_NEWX_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sw_wr_en && !status_q[BIT_NEWX] &&
     (!exc_upd_en || ((exc_upd_bits & STICKY_MASK & ~status_q) == '0))) |=> !status_q[BIT_NEWX]); // R6

  AST_INV_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sw_wr_en && exc_upd_en) |=> (!(|(status_q & INV_DETAIL_MASK)) || status_q[BIT_INVS])); // R7

  AST_CLASS_FIELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sw_wr_en && cls_wr_en) |=> status_q[CLS_LSB +: CLS_W] == $past(cls_wr_code)); // R8

  AST_RM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(round_sel) == 1); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sw_wr_en && !exc_upd_en && !cls_wr_en) |=> $stable(status_q)); // R3
endmodule

bind fp_status_unit fpsu_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .sw_wr_en     (sw_wr_en),
  .sw_wr_data   (sw_wr_data),
  .exc_upd_en   (exc_upd_en),
  .exc_upd_bits (exc_upd_bits),
  .cls_wr_en    (cls_wr_en),
  .cls_wr_code  (cls_wr_code),
  .status_q     (status_q),
  .round_sel    (round_sel)
);

// File: tb/fp_status_unit_tb.sv
module fp_status_unit_tb;
  localparam logic [31:0] INV_M = 32'h01F8_0700;
  localparam logic [31:0] STK_M = 32'h1FF8_0700;
  localparam int FLAG_IDX [13] = '{28, 27, 26, 25, 24, 23, 22, 21, 20, 19, 10, 9, 8};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic        exc_upd_en;
  logic [31:0] exc_upd_bits;
  logic        cls_wr_en;
  logic [4:0]  cls_wr_code;
  logic [31:0] status_q;
  logic [3:0]  round_sel;
  logic [3:0]  cond_field;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_w;

  always #5 clk = ~clk;

  fp_status_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .exc_upd_en(exc_upd_en), .exc_upd_bits(exc_upd_bits),
    .cls_wr_en(cls_wr_en), .cls_wr_code(cls_wr_code),
    .status_q(status_q), .round_sel(round_sel), .cond_field(cond_field)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, status_q, exp_w);
    chk({req, "/R9"}, {28'd0, round_sel}, 32'd1 << exp_w[1:0]);
    chk({req, "/R10"}, {28'd0, cond_field}, {28'd0, exp_w[31:28]});
  endtask

  // expected next word, from the requirements
  task automatic step(input logic sw, input logic [31:0] swd, input logic ee,
                      input logic [31:0] eb, input logic ce, input logic [4:0] cd,
                      input string req);
    logic [31:0] fresh;
    @(negedge clk);
    sw_wr_en = sw; sw_wr_data = swd;
    exc_upd_en = ee; exc_upd_bits = eb;
    cls_wr_en = ce; cls_wr_code = cd;
    if (sw) begin
      exp_w = swd;
    end else begin
      if (ee) begin
        fresh = eb & STK_M & ~exp_w;
        exp_w = exp_w | (eb & STK_M);
        if (fresh != 0) exp_w[31] = 1'b1;
        if ((exp_w & INV_M) != 0) exp_w[29] = 1'b1;
      end
      if (ce) exp_w[16:12] = cd;
    end
    @(posedge clk);
    #1;
    sw_wr_en = 1'b0; exc_upd_en = 1'b0; cls_wr_en = 1'b0;
    chk_outs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_wr_en = 1'b0; sw_wr_data = '0;
    exc_upd_en = 1'b0; exc_upd_bits = '0;
    cls_wr_en = 1'b0; cls_wr_code = '0;
    exp_w = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_outs("R1 reset");

    // R4: bits outside the sticky group are ignored
    step(0, 0, 1, ~STK_M, 0, 0, "R4 ignored bits");

    // R5 / R6 / R7 per flag
    foreach (FLAG_IDX[k]) begin
      step(1, 32'h0, 0, 0, 0, 0, "R2 clear");
      step(0, 0, 1, 32'd1 << FLAG_IDX[k], 0, 0, "R5 rise");
      chk("R5 newx", {31'd0, status_q[31]}, 32'd1);
      chk("R7 inv", {31'd0, status_q[29]}, {31'd0, INV_M[FLAG_IDX[k]]});
      step(1, 32'd1 << FLAG_IDX[k], 0, 0, 0, 0, "R2 preset");
      step(0, 0, 1, 32'd1 << FLAG_IDX[k], 0, 0, "R6 reassert");
      chk("R6 newx quiet", {31'd0, status_q[31]}, 32'd0);
    end

    // R3: accumulation, nothing cleared
    step(1, 32'h0, 0, 0, 0, 0, "R2 clear");
    foreach (FLAG_IDX[k]) begin
      step(0, 0, 1, 32'd1 << FLAG_IDX[k], 0, 0, "R3 accumulate");
    end
    chk("R3 all flags", status_q, 32'hBFF8_0700);
    step(0, 0, 0, 0, 0, 0, "R3 idle hold");

    // R8: every class code on a busy background
    step(1, 32'hA5A5_5A5A, 0, 0, 0, 0, "R2 background");
    for (int c = 0; c < 32; c++) begin
      step(0, 0, 0, 0, 1, c[4:0], "R8 class");
    end

    // R9: every rounding code
    for (int r = 0; r < 4; r++) begin
      step(1, 32'h0001_2300 | r, 0, 0, 0, 0, "R9 round");
    end

    // R10: every pattern of the top four bits
    for (int t = 0; t < 16; t++) begin
      step(1, t << 28, 0, 0, 0, 0, "R10 cond");
    end

    // R2: software write wins over both other paths
    step(1, 32'h0, 0, 0, 0, 0, "R2 clear");
    step(1, 32'h1234_0003, 1, 32'h0100_0000, 1, 5'h1F, "R2 priority");
    chk("R2 verbatim", status_q, 32'h1234_0003);

    // R11: exception update and class write together
    step(1, 32'h0, 0, 0, 0, 0, "R2 clear");
    step(0, 0, 1, 32'h1000_0200, 1, 5'h11, "R11 both");
    chk("R11 both", status_q, 32'hB001_1200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule